// File: doc/BRIEF.md
# Ready-Latency Packet Stream Transmitter

This block sits on the application side of a streaming transmit link. It takes packet beats from a show-ahead FIFO-style source and drives a downstream interface whose handshake has a fixed ready latency. Downstream raises ready in one cycle. That grants a transfer slot exactly `READY_LAT` cycles later, and this block may assert valid only in such a slot. The block keeps a short history of past ready values. It forwards the head beat of the source only in granted slots and pops the source in the same cycle, so backpressure never loses or repeats a beat.

Two further constraints apply. After reset is released, no beat is offered for `STARTUP_CYC` clock edges, even when ready and data are already present. On the last beat of a packet, the empty field counts the unused 64-bit words at the high end of the bus. The source is assumed to hold every beat of a packet by the time the packet's first beat reaches its head, as a store-and-forward FIFO does. Under that assumption, valid never drops inside a packet except as a consequence of ready.

Top module: `rl_pkt_tx`

## Requirements
- R1: `tx_valid_o` is high only in a cycle whose ready sample from `READY_LAT` cycles earlier was high. `READY_LAT` is a build-time parameter of 1 or 2, and its default is 2.
- R2: While reset is asserted, `tx_valid_o`, `tx_sop_o`, `tx_eop_o` and `src_pop_o` are 0. After reset is released, `tx_valid_o` stays 0 until `STARTUP_CYC` rising edges have passed (default 2), whatever the state of ready or the source.
- R3: When the startup wait is over, the current cycle is a granted slot and `src_valid_i` is high, `tx_valid_o` is high in that cycle. Inside a packet, valid therefore falls `READY_LAT` cycles after ready falls and rises `READY_LAT` cycles after ready rises.
- R4: On every beat with `tx_valid_o` high, `tx_data_o`, `tx_sop_o` and `tx_eop_o` equal the source head, and `src_pop_o` is high. `src_pop_o` is high in no other cycle. `tx_sop_o` and `tx_eop_o` are 0 whenever `tx_valid_o` is 0. Beats leave in source order, with none dropped or repeated.
- R5: On a valid end-of-packet beat with a bus wider than 64 bits, `tx_empty_o` equals `src_empty_i`, the count of unused upper qwords. A 128-bit bus has a 1-bit field, where 1 means the upper qword is unused. A 256-bit bus has a 2-bit field.
- R6: `tx_empty_o` is 0 on every beat that is not end-of-packet. It is 0 at all times on a 64-bit bus, where the port is 1 bit wide and `src_empty_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_valid_i | input | 1 | Source head holds a beat |
| src_data_i | input | DATA_W | Source head data |
| src_sop_i | input | 1 | Source head is the first beat of a packet |
| src_eop_i | input | 1 | Source head is the last beat of a packet |
| src_empty_i | input | EMPTY_W | Unused upper qwords on the last beat |
| src_pop_o | output | 1 | Removes the head beat from the source |
| tx_ready_i | input | 1 | Downstream ready, granting a slot READY_LAT cycles later |
| tx_valid_o | output | 1 | Beat transferred this cycle |
| tx_data_o | output | DATA_W | Beat data |
| tx_sop_o | output | 1 | First beat of a packet |
| tx_eop_o | output | 1 | Last beat of a packet |
| tx_empty_o | output | EMPTY_W | Unused upper qwords, nonzero only on the last beat |

## Verification
The bench builds three instances.
- A 128-bit bus with a latency of 2 and a wait of 2 covers the default one-bit empty field. Its grant edge falls on the same cycle as the end of startup.
- A 64-bit bus with a latency of 1 and a wait of 3 shows the startup wait outlasting the ready history. It also shows an empty field that must stay zero under random source values.
- A 256-bit bus with a latency of 1 exercises the two-bit qword count.

All three run the same ready patterns: continuous, random, bursty and sparse drops. A queue-based model predicts every cycle's valid, pop and beat fields.

// File: rtl/rl_pkt_tx_pkg.sv
package rl_pkt_tx_pkg;

  localparam int QWORD_W = 64;

  // width of the unused-qword count; at least one bit so the port always exists
  function automatic int empty_width(int data_w);
    int nq;
    nq = data_w / QWORD_W;
    return (nq > 2) ? $clog2(nq) : 1;
  endfunction

endpackage

// File: rtl/rl_ready_pipe.sv
module rl_ready_pipe #(
  parameter int LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_i,
  output logic grant_o
);

  logic [LAT-1:0] hist_q;

  generate
    if (LAT == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= ready_i;
      end
    end else begin : g_shift
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) hist_q <= '0;
        else         hist_q <= {hist_q[LAT-2:0], ready_i};
      end
    end
  endgenerate

  assign grant_o = hist_q[LAT-1];

endmodule

// File: rtl/rl_startup_gate.sv
module rl_startup_gate #(
  parameter int WAIT_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic open_o
);

  generate
    if (WAIT_CYC == 0) begin : g_none
      assign open_o = 1'b1;
    end else begin : g_count
      localparam int CW = $clog2(WAIT_CYC + 1);
      localparam logic [CW-1:0] LIMIT = CW'(WAIT_CYC);
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)             cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      end

      assign open_o = (cnt_q == LIMIT);
    end
  endgenerate

endmodule

// File: rtl/rl_empty_fmt.sv
module rl_empty_fmt #(
  parameter int DATA_W  = 128,
  parameter int EMPTY_W = 1
) (
  input  logic               eop_i,
  input  logic [EMPTY_W-1:0] empty_i,
  output logic [EMPTY_W-1:0] empty_o
);

  generate
    if (DATA_W <= rl_pkt_tx_pkg::QWORD_W) begin : g_narrow
      assign empty_o = '0;
    end else begin : g_wide
      assign empty_o = eop_i ? empty_i : '0;
    end
  endgenerate

endmodule

// File: rtl/rl_pkt_tx.sv
module rl_pkt_tx
  import rl_pkt_tx_pkg::*;
#(
  parameter int DATA_W      = 128,
  parameter int READY_LAT   = 2,
  parameter int STARTUP_CYC = 2,
  localparam int EMPTY_W    = empty_width(DATA_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               src_valid_i,
  input  logic [DATA_W-1:0]  src_data_i,
  input  logic               src_sop_i,
  input  logic               src_eop_i,
  input  logic [EMPTY_W-1:0] src_empty_i,
  output logic               src_pop_o,
  input  logic               tx_ready_i,
  output logic               tx_valid_o,
  output logic [DATA_W-1:0]  tx_data_o,
  output logic               tx_sop_o,
  output logic               tx_eop_o,
  output logic [EMPTY_W-1:0] tx_empty_o
);

  logic grant;
  logic open;
  logic fire;

  rl_ready_pipe #(.LAT(READY_LAT)) u_ready_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_i (tx_ready_i),
    .grant_o (grant)
  );

  rl_startup_gate #(.WAIT_CYC(STARTUP_CYC)) u_startup (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .open_o (open)
  );

  // a beat moves only in a granted slot once startup is over
  assign fire       = grant & open & src_valid_i;
  assign src_pop_o  = fire;
  assign tx_valid_o = fire;
  assign tx_data_o  = src_data_i;
  assign tx_sop_o   = fire & src_sop_i;
  assign tx_eop_o   = fire & src_eop_i;

  rl_empty_fmt #(.DATA_W(DATA_W), .EMPTY_W(EMPTY_W)) u_empty (
    .eop_i   (tx_eop_o),
    .empty_i (src_empty_i),
    .empty_o (tx_empty_o)
  );

endmodule

// File: rtl/rl_pkt_tx_chk.sv
module rl_pkt_tx_chk #(
  parameter int DATA_W      = 128,
  parameter int READY_LAT   = 2,
  parameter int STARTUP_CYC = 2,
  parameter int EMPTY_W     = 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               src_valid_i,
  input logic               src_eop_i,
  input logic               src_sop_i,
  input logic [EMPTY_W-1:0] src_empty_i,
  input logic               src_pop_o,
  input logic               tx_ready_i,
  input logic               tx_valid_o,
  input logic               tx_sop_o,
  input logic               tx_eop_o,
  input logic [EMPTY_W-1:0] tx_empty_o
);

  int unsigned cyc_q;
  logic        in_pkt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q    <= 0;
      in_pkt_q <= 1'b0;
    end else begin
      if (cyc_q != 32'hffff_ffff) cyc_q <= cyc_q + 1;
      if (tx_valid_o && tx_eop_o)      in_pkt_q <= 1'b0;
      else if (tx_valid_o && tx_sop_o) in_pkt_q <= 1'b1;
    end
  end

  p_grant_slot_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (cyc_q >= READY_LAT) && $past(tx_ready_i, READY_LAT));

  p_startup_wait_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q < STARTUP_CYC) |-> !tx_valid_o);

  p_no_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_pkt_q && cyc_q >= READY_LAT && cyc_q >= STARTUP_CYC &&
     $past(tx_ready_i, READY_LAT) && src_valid_i) |-> tx_valid_o);

  p_pop_on_beat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> src_pop_o && src_valid_i);

  p_markers_gated_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_valid_o |-> !tx_sop_o && !tx_eop_o && !src_pop_o);

  p_empty_last_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_eop_o && DATA_W > 64) |-> tx_empty_o == src_empty_i);

  p_empty_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_eop_o || DATA_W <= 64) |-> tx_empty_o == '0);

  p_eop_matches_src_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (tx_eop_o == src_eop_i) && (tx_sop_o == src_sop_i));

endmodule

bind rl_pkt_tx rl_pkt_tx_chk #(
  .DATA_W(DATA_W), .READY_LAT(READY_LAT), .STARTUP_CYC(STARTUP_CYC), .EMPTY_W(EMPTY_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_valid_i(src_valid_i), .src_eop_i(src_eop_i),
  .src_sop_i(src_sop_i), .src_empty_i(src_empty_i), .src_pop_o(src_pop_o),
  .tx_ready_i(tx_ready_i), .tx_valid_o(tx_valid_o), .tx_sop_o(tx_sop_o),
  .tx_eop_o(tx_eop_o), .tx_empty_o(tx_empty_o)
);

// File: tb/rl_pkt_tx_tb.sv
`timescale 1ns/1ps

module rl_pkt_tx_env #(
  parameter int DW    = 128,
  parameter int LAT   = 2,
  parameter int WAITC = 2,
  parameter int NCYC  = 3000
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_chk,
  output int   n_fail,
  output logic done
);

  localparam int EW = rl_pkt_tx_pkg::empty_width(DW);

  typedef struct packed {
    logic [DW-1:0] d;
    logic          s;
    logic          e;
    logic [EW-1:0] m;
  } beat_t;

  beat_t q[$];
  bit    rh[$];
  int    edges;
  bit    exp_v;
  int    burst_left;

  logic          src_valid, src_sop, src_eop, src_pop, ready;
  logic [DW-1:0] src_data;
  logic [EW-1:0] src_empty;
  logic          tx_valid, tx_sop, tx_eop;
  logic [DW-1:0] tx_data;
  logic [EW-1:0] tx_empty;

  rl_pkt_tx #(.DATA_W(DW), .READY_LAT(LAT), .STARTUP_CYC(WAITC)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .src_valid_i(src_valid), .src_data_i(src_data), .src_sop_i(src_sop),
    .src_eop_i(src_eop), .src_empty_i(src_empty), .src_pop_o(src_pop),
    .tx_ready_i(ready), .tx_valid_o(tx_valid), .tx_data_o(tx_data),
    .tx_sop_o(tx_sop), .tx_eop_o(tx_eop), .tx_empty_o(tx_empty)
  );

  task automatic chk(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s DW=%0d LAT=%0d edge=%0d act=%h exp=%h",
               tag, what, DW, LAT, edges, act, expv);
    end
  endtask

  task automatic add_pkt();
    int    len;
    beat_t b;
    len = 1 + int'($urandom % 5);
    for (int i = 0; i < len; i++) begin
      for (int w = 0; w < DW / 32; w++) b.d[w*32 +: 32] = $urandom;
      b.s = (i == 0);
      b.e = (i == len - 1);
      b.m = EW'($urandom);
      q.push_back(b);
    end
  endtask

  task automatic drive_src();
    if (q.size() > 0) begin
      src_valid = 1'b1;
      src_data  = q[0].d;
      src_sop   = q[0].s;
      src_eop   = q[0].e;
      src_empty = q[0].m;
    end else begin
      src_valid = 1'b0;
      src_data  = '0;
      src_sop   = 1'b1;
      src_eop   = 1'b1;
      src_empty = EW'($urandom);
    end
  endtask

  task automatic drive_ready(int c);
    if (c < 200) ready = 1'b1;
    else if (c < 1200) ready = $urandom % 2;
    else if (c < 2200) begin
      if (burst_left == 0) begin
        ready      = ~ready;
        burst_left = 1 + int'($urandom % 6);
      end else burst_left--;
    end else ready = ($urandom % 8) != 0;
  endtask

  task automatic check_cycle();
    bit            head, ev;
    string         tag;
    beat_t         b;
    logic [EW-1:0] em;
    head = (rh.size() >= LAT) ? rh[LAT-1] : 1'b0;
    ev   = (edges >= WAITC) && head && (q.size() > 0);
    tag  = (edges < WAITC) ? "R2" : (!head ? "R1" : "R3");
    chk(tx_valid == ev, tag, "valid", DW'(tx_valid), DW'(ev));
    chk(src_pop == ev, "R4", "pop", DW'(src_pop), DW'(ev));
    if (ev) begin
      b = q[0];
      chk(tx_data == b.d, "R4", "data", tx_data, b.d);
      chk(tx_sop == b.s && tx_eop == b.e, "R4", "sop_eop",
          DW'({tx_sop, tx_eop}), DW'({b.s, b.e}));
      em = (DW > 64 && b.e) ? b.m : '0;
      chk(tx_empty == em, (DW > 64 && b.e) ? "R5" : "R6", "empty", DW'(tx_empty), DW'(em));
    end else begin
      chk(!tx_sop && !tx_eop, "R4", "idle_markers", DW'({tx_sop, tx_eop}), '0);
      chk(tx_empty == '0, "R6", "idle_empty", DW'(tx_empty), '0);
    end
    exp_v = ev;
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    edges = 0; exp_v = 1'b0; burst_left = 0;
    ready = 1'b1;
    add_pkt();
    drive_src();
    @(negedge clk);
    #1;
    chk(!tx_valid && !src_pop && !tx_sop && !tx_eop, "R2", "reset_outputs",
        DW'({tx_valid, src_pop, tx_sop, tx_eop}), '0);
    wait (rst_n === 1'b1);
    for (int c = 0; c < NCYC; c++) begin
      @(posedge clk);
      if (exp_v) void'(q.pop_front());
      rh.push_front(ready);
      if (rh.size() > 4) void'(rh.pop_back());
      edges++;
      @(negedge clk);
      if (q.size() < 6 && ($urandom % 3) == 0 && c < NCYC - 50) add_pkt();
      drive_src();
      drive_ready(c);
      #1;
      check_cycle();
    end
    done = 1'b1;
  end

endmodule

module rl_pkt_tx_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   c0, f0, c1, f1, c2, f2;
  logic d0, d1, d2;
  bit   ended = 1'b0;

  always #4 clk = ~clk;

  rl_pkt_tx_env #(.DW(128), .LAT(2), .WAITC(2)) u_env_a (
    .clk(clk), .rst_n(rst_n), .n_chk(c0), .n_fail(f0), .done(d0));
  rl_pkt_tx_env #(.DW(64), .LAT(1), .WAITC(3)) u_env_b (
    .clk(clk), .rst_n(rst_n), .n_chk(c1), .n_fail(f1), .done(d1));
  rl_pkt_tx_env #(.DW(256), .LAT(1), .WAITC(2)) u_env_c (
    .clk(clk), .rst_n(rst_n), .n_chk(c2), .n_fail(f2), .done(d2));

  initial begin
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    wait (d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1);
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", c0 + c1 + c2, f0 + f1 + f2);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      $display("FAIL watchdog: run did not complete act=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", c0 + c1 + c2 + 1, f0 + f1 + f2 + 1);
      $finish;
    end
  end

endmodule